// File: doc/BRIEF.md
# Two-Byte I2C Slave Register Port

This block is the slave end of a two-wire serial control link, running entirely in a fast system clock domain. The SCL and SDA inputs are synchronized and filtered against short spikes, and bus edges and START/STOP conditions are taken from the cleaned lines. A transaction is framed as exactly one 16-bit word. A write delivers two data bytes, a command byte and then a control byte, which leave the block as one word with a one-cycle strobe. A read returns a 16-bit status word taken from a neighbouring block, high byte first.

The slave address has seven bits: a fixed 1010 prefix on top and three strap pins below it. The block never drives SCL. It drives SDA only through an open-drain pull-low enable, and that enable changes only while SCL is low.

The control state machine has seven states:
- IDLE: waits for a START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the address acknowledge.
- WR_BYTE: shifts in a data byte.
- WR_ACK: acknowledges a data byte.
- RD_BYTE: shifts out a status byte.
- RD_ACK: samples the master's acknowledge.

Its transitions are:
- START in any state goes to ADDR.
- STOP in any state goes to IDLE.
- From ADDR, the SCL fall after eight bits goes to ADDR_ACK on an address match and to IDLE on a mismatch.
- From ADDR_ACK, the next SCL fall goes to RD_BYTE or WR_BYTE, depending on the direction bit.
- From WR_BYTE, the fall after eight bits goes to WR_ACK.
- From WR_ACK, the next fall goes back to WR_BYTE after the first byte, or to IDLE after the second byte together with the strobe.
- From RD_BYTE, the eighth fall goes to RD_ACK.
- From RD_ACK, the next fall goes to RD_BYTE if the master acknowledged the first byte, and to IDLE otherwise.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset the SDA pull-low enable is off and the write strobe is low.
- R2: An address byte whose upper seven bits equal 1010 followed by strap_i[2:0] (strap_i[2] first) is acknowledged by pulling SDA low during the ninth clock. The byte's LSB selects read (1) or write (0).
- R3: An address that does not match is not acknowledged, and the slave drives SDA for nothing else until the next START.
- R4: On a write, both data bytes are acknowledged, and bits arrive MSB first. After the SCL fall that ends the second acknowledge, wr_vld_o is high for one clock cycle with wr_word_o = {first byte, second byte}.
- R5: A STOP or repeated START that arrives before the second data byte is acknowledged discards the partial word, and no strobe is given for it.
- R6: On a read, the slave sends stat_i[15:8] and then stat_i[7:0], each MSB first. The word is captured when the address is acknowledged, so later changes of stat_i have no effect on that transfer.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives it no more until the next START.
- R8: A repeated START restarts address reception, and the transaction that follows behaves as if it followed a fresh START.
- R9: An SCL pulse shorter than the filter window is not counted as a clock edge.
- R10: The SDA pull-low enable changes only while SCL is low.
- R11: A third data byte on a write is not acknowledged and does not change the word already strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three address bits; bit 2 is sent first |
| stat_i | input | 16 | Status word returned on a read |
| sda_oe_o | output | 1 | High to pull SDA low |
| wr_word_o | output | 16 | Last written word, first byte in the upper half |
| wr_vld_o | output | 1 | One-cycle strobe marking a new wr_word_o |

## Verification
The hardest states to reach from the ports are the discard paths and the late-byte path. These are a transfer that is broken off after one data byte by a STOP or a repeated START, and a third byte that follows a complete word. The bench's bus master builds these sequences bit by bit, and the scoreboard holds no expected word for them, so any strobe is flagged as unexpected. Filter rejection is reached by inserting a two-cycle SCL pulse into the low phase of every bit of a write, and the received word must still match. Status capture is tested by changing stat_i right after the address acknowledge.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR_BYTE  = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD_BYTE  = 3'd5,
        ST_RD_ACK   = 3'd6
    } slv_state_t;

endpackage

// File: rtl/i2cw_glitch_filter.sv
module i2cw_glitch_filter #(
    parameter int STABLE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // two-flop synchronizer, then a change must persist STABLE_CYC cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(STABLE_CYC - 1)) begin
                line_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R9: the filtered line only ever moves to the value it was offered
    assert_filter_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> (line_o == $past(sync_q[1])));

endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        scl_rise_o = scl_f & ~scl_p;
        scl_fall_o = ~scl_f & scl_p;
        start_o    = scl_f & scl_p & sda_p & ~sda_f;
        stop_o     = scl_f & scl_p & ~sda_p & sda_f;
    end

endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter int         BYTE_W      = 8,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] ADDR_PREFIX = 4'b1010,
    localparam int        WORD_W      = 2 * BYTE_W,
    localparam int        CNT_W       = $clog2(BYTE_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_f,
    input  logic               sda_f,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [WORD_W-1:0]  stat_i,
    output logic               sda_oe_o,
    output logic [WORD_W-1:0]  wr_word_o,
    output logic               wr_vld_o
);
    slv_state_t        st_q, st_nx;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              rw_q;
    logic              second_q;
    logic              mack_q;
    logic              bit_full;
    logic              addr_hit;

    assign bit_full = (bit_cnt_q == CNT_W'(BYTE_W));
    assign addr_hit = (shreg_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (stop_ev) begin
            st_nx = ST_IDLE;
        end else if (start_ev) begin
            st_nx = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_full)
                                 st_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)
                                 st_nx = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bit_full)
                                 st_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 st_nx = second_q ? ST_IDLE : ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt_q == CNT_W'(BYTE_W - 1))
                                 st_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 st_nx = (mack_q && !second_q) ? ST_RD_BYTE : ST_IDLE;
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            rw_q      <= 1'b0;
            second_q  <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_word_o <= '0;
            wr_vld_o  <= 1'b0;
        end else begin
            wr_vld_o <= 1'b0;
            if (stop_ev || start_ev) begin
                sda_oe_o  <= 1'b0;
                bit_cnt_q <= '0;
                second_q  <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        sda_oe_o <= 1'b0;
                    end
                    ST_ADDR: begin
                        if (scl_rise && !bit_full) begin
                            shreg_q   <= {shreg_q[WORD_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall && bit_full) begin
                            bit_cnt_q <= '0;
                            if (addr_hit) begin
                                sda_oe_o <= 1'b1;
                                rw_q     <= shreg_q[0];
                                shreg_q  <= stat_i;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall)
                            sda_oe_o <= rw_q ? ~shreg_q[WORD_W-1] : 1'b0;
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise && !bit_full) begin
                            shreg_q   <= {shreg_q[WORD_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall && bit_full) begin
                            sda_oe_o  <= 1'b1;
                            bit_cnt_q <= '0;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            if (second_q) begin
                                wr_word_o <= shreg_q;
                                wr_vld_o  <= 1'b1;
                                second_q  <= 1'b0;
                            end else begin
                                second_q <= 1'b1;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                            if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
                                sda_oe_o  <= 1'b0;
                                bit_cnt_q <= '0;
                            end else begin
                                sda_oe_o  <= ~shreg_q[WORD_W-2];
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)
                            mack_q <= ~sda_f;
                        if (scl_fall) begin
                            if (mack_q && !second_q) begin
                                second_q <= 1'b1;
                                sda_oe_o <= ~shreg_q[WORD_W-1];
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end
        end
    end

    // R2: the address acknowledge only follows a matching address byte
    assert_ack_matched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && $past(st_q) == ST_ADDR)
        |-> ($past(shreg_q[BYTE_W-1:1]) == {ADDR_PREFIX, $past(strap_i)}));

    // R3: a slave that has settled in idle leaves SDA alone
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !sda_oe_o);

    // R4: the strobe is a single cycle and comes out of the write acknowledge
    assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld_o |=> !wr_vld_o);
    assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld_o |-> ($past(st_q) == ST_WR_ACK && !scl_f));

    // R6: the captured status word holds between SCL falls while sending
    assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD_BYTE && $past(st_q) == ST_RD_BYTE && !$past(scl_fall))
        |-> $stable(shreg_q));

    // R10: the pull-low enable moves only while SCL is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_f);

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave #(
    parameter int         BYTE_W      = 8,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] ADDR_PREFIX = 4'b1010,
    parameter int         FILT_CYC    = 10,
    localparam int        WORD_W      = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [WORD_W-1:0]  stat_i,
    output logic               sda_oe_o,
    output logic [WORD_W-1:0]  wr_word_o,
    output logic               wr_vld_o
);
    logic [1:0] raw_lines;
    logic [1:0] clean_lines;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cw_glitch_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2cw_bus_events u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (clean_lines[1]),
        .sda_f      (clean_lines[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2cw_engine #(
        .BYTE_W      (BYTE_W),
        .STRAP_W     (STRAP_W),
        .ADDR_PREFIX (ADDR_PREFIX)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[1]),
        .sda_f     (clean_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .strap_i   (strap_i),
        .stat_i    (stat_i),
        .sda_oe_o  (sda_oe_o),
        .wr_word_o (wr_word_o),
        .wr_vld_o  (wr_vld_o)
    );

endmodule

// File: tb/sim_i2c_word_slave.sv
module sim_i2c_word_slave;
    localparam int Q = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_w;
    logic [2:0]  strap = 3'b101;
    logic [15:0] stat = 16'h0000;
    logic        sda_oe;
    logic [15:0] wr_word;
    logic        wr_vld;

    int          n_vec = 0;
    int          n_bad = 0;
    int          n_strobe = 0;
    int          oe_bad = 0;
    bit          oe_seen = 0;
    logic        oe_prev = 1'b0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_w = sda_m & ~sda_oe;

    i2c_word_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_w),
        .strap_i   (strap),
        .stat_i    (stat),
        .sda_oe_o  (sda_oe),
        .wr_word_o (wr_word),
        .wr_vld_o  (wr_vld)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; tick(Q);
        sda_m = 0; tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1; tick(Q);
        scl_m = 1; tick(Q);
        sda_m = 0; tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(Q);
        scl_m = 1; tick(Q);
        sda_m = 1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(10); scl_m = 1; tick(2); scl_m = 0; tick(Q - 12);
        end else begin
            tick(Q);
        end
        scl_m = 1; tick(2 * Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
        sda_m = 1; tick(Q);
        scl_m = 1; tick(Q);
        ack = !sda_w; tick(Q);
        scl_m = 0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1; tick(Q);
            d[i] = sda_w; tick(Q);
            scl_m = 0; tick(Q);
        end
        send_bit(!mack, 1'b0);
    endtask

    // scoreboard monitor: every strobe pops one expected word
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_vld) begin
                n_strobe++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 strobe with no word expected", wr_word, 16'h0000);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(wr_word == e, "R4 strobed write word", wr_word, e);
                end
            end
            if (sda_oe != oe_prev && scl_m) oe_bad++;
            if (sda_oe) oe_seen = 1;
        end
        oe_prev = sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit          a;
        bit          a1;
        bit          a2;
        bit          a3;
        logic [7:0]  d;
        int          s0;

        tick(5);
        check(sda_oe == 1'b0, "R1 reset enable", {15'd0, sda_oe}, 16'h0000);
        check(wr_vld == 1'b0, "R1 reset strobe", {15'd0, wr_vld}, 16'h0000);
        rst_n = 1; tick(20);

        // R2/R4: plain write, address 1010_101 + W = 0xAA
        exp_q.push_back(16'h5C93);
        bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h5C, 0, a1); send_byte(8'h93, 0, a2); bus_stop();
        check(a, "R2 address ack", {15'd0, a}, 16'h0001);
        check(a1 && a2, "R4 data byte acks", {14'd0, a1, a2}, 16'h0003);
        check(exp_q.size() == 0, "R4 word delivered", 16'(exp_q.size()), 16'h0000);

        // R3: wrong straps in the address (001), nothing acknowledged
        s0 = n_strobe;
        oe_seen = 0;
        bus_start(); send_byte(8'hA2, 0, a); send_byte(8'h12, 0, a1); send_byte(8'h34, 0, a2); bus_stop();
        check(!a, "R3 mismatch not acked", {15'd0, a}, 16'h0000);
        check(!oe_seen, "R3 SDA untouched after mismatch", {15'd0, oe_seen}, 16'h0000);
        check(n_strobe == s0, "R3 no strobe on mismatch", 16'(n_strobe - s0), 16'h0000);

        // R5: one data byte, then STOP
        s0 = n_strobe;
        bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h11, 0, a1); bus_stop();
        check(n_strobe == s0, "R5 partial word dropped on STOP", 16'(n_strobe - s0), 16'h0000);

        // R5/R8: one data byte, repeated START, then a full write
        exp_q.push_back(16'h3344);
        bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h22, 0, a1);
        bus_rstart(); send_byte(8'hAA, 0, a); send_byte(8'h33, 0, a1); send_byte(8'h44, 0, a2); bus_stop();
        check(a, "R8 address acked after repeated START", {15'd0, a}, 16'h0001);
        check(n_strobe == s0 + 1, "R5 only the completed word strobed", 16'(n_strobe - s0), 16'h0001);
        check(exp_q.size() == 0, "R8 word after repeated START", 16'(exp_q.size()), 16'h0000);

        // R6: read, status captured at the address acknowledge
        stat = 16'hA53C;
        bus_start(); send_byte(8'hAB, 0, a);
        stat = 16'h0000;
        check(a, "R2 read address ack", {15'd0, a}, 16'h0001);
        recv_byte(1, d);
        check(d == 8'hA5, "R6 read high byte", {8'd0, d}, 16'h00A5);
        recv_byte(0, d);
        check(d == 8'h3C, "R6 read low byte", {8'd0, d}, 16'h003C);
        bus_stop();

        // R7: master NACKs the first byte, slave goes quiet
        stat = 16'h7E81;
        bus_start(); send_byte(8'hAB, 0, a);
        recv_byte(0, d);
        check(d == 8'h7E, "R7 first read byte", {8'd0, d}, 16'h007E);
        oe_seen = 0;
        recv_byte(0, d);
        check(d == 8'hFF, "R7 bus released after NACK", {8'd0, d}, 16'h00FF);
        check(!oe_seen, "R7 no drive after NACK", {15'd0, oe_seen}, 16'h0000);
        bus_stop();

        // R11: third data byte is refused
        exp_q.push_back(16'hC30F);
        s0 = n_strobe;
        bus_start(); send_byte(8'hAA, 0, a); send_byte(8'hC3, 0, a1); send_byte(8'h0F, 0, a2);
        send_byte(8'hF0, 0, a3); bus_stop();
        check(!a3, "R11 third byte not acked", {15'd0, a3}, 16'h0000);
        check(n_strobe == s0 + 1 && wr_word == 16'hC30F, "R11 word unchanged", wr_word, 16'hC30F);

        // R9: short SCL pulse in the low phase of every bit
        exp_q.push_back(16'h6A95);
        bus_start(); send_byte(8'hAA, 1, a); send_byte(8'h6A, 1, a1); send_byte(8'h95, 1, a2); bus_stop();
        check(a && a1 && a2, "R9 acks with spikes present", {13'd0, a, a1, a2}, 16'h0007);
        check(exp_q.size() == 0, "R9 word with spikes", 16'(exp_q.size()), 16'h0000);

        // R2: new straps 010, address 0xA4 matches and 0xAA no longer does
        strap = 3'b010;
        tick(10);
        bus_start(); send_byte(8'hAA, 0, a); bus_stop();
        check(!a, "R2 old address after strap change", {15'd0, a}, 16'h0000);
        exp_q.push_back(16'h0180);
        bus_start(); send_byte(8'hA4, 0, a); send_byte(8'h01, 0, a1); send_byte(8'h80, 0, a2); bus_stop();
        check(a, "R2 new strap address", {15'd0, a}, 16'h0001);
        check(exp_q.size() == 0, "R4 word at new address", 16'(exp_q.size()), 16'h0000);

        check(oe_bad == 0, "R10 enable changed with SCL high", 16'(oe_bad), 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule